// File: doc/BRIEF.md
# Command-Byte Serial Register Port

This block is the host-facing serial port of a converter-style peripheral. An external controller reaches eight internal registers through a half-duplex SPI-compatible link made of a serial clock, a data input and a data output, plus a chip select that may simply be tied low. The serial clock rests high, and the link runs in clock polarity 1, clock phase 1 mode. The slave changes its output on each falling clock edge. It takes input on each rising edge.

Every access starts with an 8-bit command byte. The command byte names a target register and a direction. The slave then moves exactly as many bits as that register holds (8, 16 or 24), most significant bit first, and goes back to waiting for a command. The conversion engine sits outside the block. It shows up only as a one-cycle strobe carrying a 16-bit sample. Each strobe updates the conversion-data register and raises a data-ready flag. The host sees that flag on an active-low pin and in bit 7 of the status byte.

All serial inputs are brought into the system clock domain through a synchronizer. Edges are detected there, so the serial clock must be several times slower than the system clock.

Top module: `comm_spi_slave`

## Requirements
- R1: After reset, miso is 0 and drdy_n is 1. The registers hold these values: setup = 0x01, full-scale calibration = 0x800000, and every other register = 0.
- R2: Command byte layout: bit 7 must be 0, bits 6:4 select the register, bit 3 is 1 for a read and 0 for a write, and bits 2:0 are ignored. A byte with bit 7 set is discarded, and the byte after it is taken as a new command.
- R3: Register select codes and lengths: 0 status (8 bits, read only), 1 setup (8), 2 clock (8), 3 conversion data (16, read only; a write moves 16 bits and changes nothing), 4 test (8), 5 auxiliary (8), 6 zero-scale calibration (24), 7 full-scale calibration (24).
- R4: All fields are shifted most significant bit first. The data phase starts on the serial clock that follows the eighth command bit, so a command byte and its data can be sent as one continuous transfer.
- R5: The port is half-duplex. miso is 0 except during the data phase of a read, and mosi has no effect during that phase.
- R6: The serial clock may stay high for any time between bits or bytes while chip select is low. A 24-bit register can therefore be written as three separate 8-bit pieces, and chip select may stay low for the whole session.
- R7: If chip select goes high in the middle of a command or data phase, the transfer is abandoned. A partly shifted write never reaches its register, and the next byte is decoded as a command.
- R8: A sample strobe sets data-ready. drdy_n goes low one clock after the strobe, and bit 7 of the status byte reads 1. Reading the status byte leaves the flag unchanged. The flag is cleared when the last bit of a conversion-data read is clocked.
- R9: A conversion-data read returns the sample that was held when its command byte completed. A strobe that arrives during the read changes only later reads.
- R10: A write command that targets select 0 has no data phase. The next 8 bits are a new command.
- R11: A change on sclk or cs_n is acted on at the third rising clk edge after it. miso, drdy_n and register contents change at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk | input | 1 | Serial clock from the host, rests high |
| cs_n | input | 1 | Active-low chip select, may be tied low |
| mosi | input | 1 | Serial data from the host, taken on rising sclk |
| miso | output | 1 | Serial data to the host, changed on falling sclk |
| sample_valid | input | 1 | One-cycle strobe from the conversion engine |
| sample_data | input | 16 | Sample that goes with the strobe |
| drdy_n | output | 1 | Active-low data-ready indication |

## Verification
Serial results are due on the third rising clk edge after the sclk or cs_n change that causes them. This covers the miso update after a falling edge, the read decode and register update after a rising edge, and the forced idle after chip select rises. The drdy_n set is due one edge after a strobe. The bench's behavioural model updates its expected miso and drdy_n at those same edges, and the model is compared with the pins at every falling clk edge. Register contents are checked on whole read transfers, where the host captures each miso bit just before it raises sclk.

// File: rtl/comm_spi_pkg.sv
package comm_spi_pkg;
  localparam int SEL_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 16;
  localparam int CAL_W   = 24;
  localparam int SHIFT_W = 24;
  localparam int CNT_W   = $clog2(SHIFT_W + 1);
  localparam int CMD_W   = 8;

  // command byte field positions
  localparam int CMD_NRDY_BIT = 7;
  localparam int CMD_SEL_LSB  = 4;
  localparam int CMD_RD_BIT   = 3;

  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_WR = 2'd1, PH_RD = 2'd2} phase_t;

  localparam logic [SEL_W-1:0] SEL_STAT  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SETUP = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CLK   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATA  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_TEST  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_AUX   = 3'd5;
  localparam logic [SEL_W-1:0] SEL_ZCAL  = 3'd6;
  localparam logic [SEL_W-1:0] SEL_FCAL  = 3'd7;

  localparam int N_BYTE_REGS = 4;
  localparam int N_CAL_REGS  = 2;

  localparam logic [N_BYTE_REGS*SEL_W-1:0]  BYTE_SEL_MAP = {SEL_AUX, SEL_TEST, SEL_CLK, SEL_SETUP};
  localparam logic [N_BYTE_REGS*BYTE_W-1:0] BYTE_RST_MAP = {8'h00, 8'h00, 8'h00, 8'h01};
  localparam logic [N_CAL_REGS*SEL_W-1:0]   CAL_SEL_MAP  = {SEL_FCAL, SEL_ZCAL};
  localparam logic [N_CAL_REGS*CAL_W-1:0]   CAL_RST_MAP  = {24'h800000, 24'h000000};

  function automatic logic [CNT_W-1:0] reg_len(input logic [SEL_W-1:0] s);
    case (s)
      SEL_DATA:           reg_len = CNT_W'(DATA_W);
      SEL_ZCAL, SEL_FCAL: reg_len = CNT_W'(CAL_W);
      default:            reg_len = CNT_W'(BYTE_W);
    endcase
  endfunction
endpackage

// File: rtl/comm_spi_sync.sv
module comm_spi_sync #(
  parameter int STAGES = 2  // must be 2 or more
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_q, sclk_n;
  logic [STAGES-1:0] cs_q, cs_n_nx;
  logic [STAGES-1:0] mosi_q, mosi_n;
  logic              prev_q, prev_n;

  always_comb begin
    sclk_n  = {sclk_q[STAGES-2:0], sclk};
    cs_n_nx = {cs_q[STAGES-2:0], cs_n};
    mosi_n  = {mosi_q[STAGES-2:0], mosi};
    prev_n  = sclk_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      cs_q   <= '1;
      mosi_q <= '0;
      prev_q <= 1'b1;
    end else begin
      sclk_q <= sclk_n;
      cs_q   <= cs_n_nx;
      mosi_q <= mosi_n;
      prev_q <= prev_n;
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~prev_q;
  assign sclk_fall = ~sclk_q[STAGES-1] & prev_q;
  assign cs_idle   = cs_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];

  // R11: a detected edge comes from a level that was already held one cycle earlier
  assert_edge_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |-> $past(sclk_q[STAGES-2]));
endmodule

// File: rtl/comm_spi_seq.sv
module comm_spi_seq
  import comm_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_idle,
  input  logic               mosi_s,
  input  logic [SHIFT_W-1:0] rd_word,
  output logic [SEL_W-1:0]   rd_sel,
  output logic [SEL_W-1:0]   wr_sel,
  output logic               wr_en,
  output logic [SHIFT_W-1:0] wr_word,
  output logic               data_rd_done,
  output logic               miso
);
  phase_t             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [SHIFT_W-2:0] shin_q, shin_n;
  logic [SHIFT_W-1:0] shout_q, shout_n;
  logic [SEL_W-1:0]   sel_q, sel_n;
  logic               miso_q, miso_n;

  logic [SHIFT_W-1:0] shin_next;
  logic [CNT_W-1:0]   len;
  logic               last_bit;

  assign shin_next = {shin_q, mosi_s};
  assign len       = reg_len(sel_q);
  assign last_bit  = (cnt_q == len - CNT_W'(1));
  assign rd_sel    = shin_next[CMD_SEL_LSB +: SEL_W];
  assign wr_sel    = sel_q;
  assign wr_word   = shin_next;
  assign miso      = miso_q;

  always_comb begin
    phase_n      = phase_q;
    cnt_n        = cnt_q;
    shin_n       = shin_q;
    shout_n      = shout_q;
    sel_n        = sel_q;
    miso_n       = miso_q;
    wr_en        = 1'b0;
    data_rd_done = 1'b0;
    if (cs_idle) begin
      phase_n = PH_CMD;
      cnt_n   = '0;
      miso_n  = 1'b0;
    end else begin
      case (phase_q)
        PH_CMD: begin
          if (sclk_rise) begin
            shin_n = shin_next[SHIFT_W-2:0];
            cnt_n  = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(CMD_W - 1)) begin
              cnt_n = '0;
              if (!shin_next[CMD_NRDY_BIT]) begin
                sel_n = shin_next[CMD_SEL_LSB +: SEL_W];
                if (shin_next[CMD_RD_BIT]) begin
                  phase_n = PH_RD;
                  shout_n = rd_word;
                end else if (shin_next[CMD_SEL_LSB +: SEL_W] != SEL_STAT) begin
                  phase_n = PH_WR;
                end
              end
            end
          end
        end
        PH_WR: begin
          if (sclk_rise) begin
            shin_n = shin_next[SHIFT_W-2:0];
            cnt_n  = cnt_q + CNT_W'(1);
            if (last_bit) begin
              wr_en   = 1'b1;
              phase_n = PH_CMD;
              cnt_n   = '0;
            end
          end
        end
        PH_RD: begin
          if (sclk_fall) begin
            miso_n  = shout_q[SHIFT_W-1];
            shout_n = {shout_q[SHIFT_W-2:0], 1'b0};
          end
          if (sclk_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
            if (last_bit) begin
              phase_n      = PH_CMD;
              cnt_n        = '0;
              miso_n       = 1'b0;
              data_rd_done = (sel_q == SEL_DATA);
            end
          end
        end
        default: phase_n = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      sel_q   <= SEL_STAT;
      miso_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      shin_q  <= shin_n;
      shout_q <= shout_n;
      sel_q   <= sel_n;
      miso_q  <= miso_n;
    end
  end

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (phase_q == PH_CMD && cnt_q == '0 && miso_q == 1'b0));

  assert_badcmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_idle && sclk_rise && phase_q == PH_CMD && cnt_q == CNT_W'(CMD_W - 1) && shin_q[CMD_NRDY_BIT-1])
    |=> phase_q == PH_CMD);

  assert_halfdup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RD) |-> (miso_q == 1'b0));

  assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_CMD) |-> (cnt_q < reg_len(sel_q)));
endmodule

// File: rtl/comm_spi_regbank.sv
module comm_spi_regbank
  import comm_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_valid,
  input  logic [DATA_W-1:0]  sample_data,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [SHIFT_W-1:0] wr_word,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic               data_rd_done,
  output logic [SHIFT_W-1:0] rd_word,
  output logic               drdy_n
);
  logic [N_BYTE_REGS*BYTE_W-1:0] byte_flat;
  logic [N_CAL_REGS*CAL_W-1:0]   cal_flat;
  logic [DATA_W-1:0]             data_q, data_n;
  logic                          rdy_q, rdy_n;

  for (genvar g = 0; g < N_BYTE_REGS; g++) begin : g_byte
    logic [BYTE_W-1:0] val_q, val_n;
    logic              hit;
    assign hit = wr_en && (wr_sel == BYTE_SEL_MAP[g*SEL_W +: SEL_W]);
    always_comb val_n = hit ? wr_word[BYTE_W-1:0] : val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= BYTE_RST_MAP[g*BYTE_W +: BYTE_W];
      else        val_q <= val_n;
    end
    assign byte_flat[g*BYTE_W +: BYTE_W] = val_q;
  end

  for (genvar g = 0; g < N_CAL_REGS; g++) begin : g_cal
    logic [CAL_W-1:0] val_q, val_n;
    logic             hit;
    assign hit = wr_en && (wr_sel == CAL_SEL_MAP[g*SEL_W +: SEL_W]);
    always_comb val_n = hit ? wr_word[CAL_W-1:0] : val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= CAL_RST_MAP[g*CAL_W +: CAL_W];
      else        val_q <= val_n;
    end
    assign cal_flat[g*CAL_W +: CAL_W] = val_q;
  end

  always_comb begin
    data_n = sample_valid ? sample_data : data_q;
    rdy_n  = rdy_q;
    if (data_rd_done) rdy_n = 1'b0;
    if (sample_valid) rdy_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      rdy_q  <= rdy_n;
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_sel == SEL_STAT) rd_word[SHIFT_W-1] = rdy_q;
    if (rd_sel == SEL_DATA) rd_word[SHIFT_W-1 -: DATA_W] = data_q;
    for (int g = 0; g < N_BYTE_REGS; g++) begin
      if (rd_sel == BYTE_SEL_MAP[g*SEL_W +: SEL_W])
        rd_word[SHIFT_W-1 -: BYTE_W] = byte_flat[g*BYTE_W +: BYTE_W];
    end
    for (int g = 0; g < N_CAL_REGS; g++) begin
      if (rd_sel == CAL_SEL_MAP[g*SEL_W +: SEL_W])
        rd_word[SHIFT_W-1 -: CAL_W] = cal_flat[g*CAL_W +: CAL_W];
    end
  end

  assign drdy_n = ~rdy_q;

  assert_drdy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !drdy_n);

  assert_drdy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !data_rd_done) |=> (rdy_q == $past(rdy_q)));

  assert_data_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DATA && !sample_valid) |=> (data_q == $past(data_q)));
endmodule

// File: rtl/comm_spi_slave.sv
module comm_spi_slave
  import comm_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  output logic              drdy_n
);
  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic               sclk_rise, sclk_fall, cs_idle, mosi_s;
  logic [SHIFT_W-1:0] rd_word, wr_word;
  logic [SEL_W-1:0]   rd_sel, wr_sel;
  logic               wr_en, data_rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  comm_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_idle   (cs_idle),
    .mosi_s    (mosi_s)
  );

  comm_spi_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sclk_rise    (sclk_rise),
    .sclk_fall    (sclk_fall),
    .cs_idle      (cs_idle),
    .mosi_s       (mosi_s),
    .rd_word      (rd_word),
    .rd_sel       (rd_sel),
    .wr_sel       (wr_sel),
    .wr_en        (wr_en),
    .wr_word      (wr_word),
    .data_rd_done (data_rd_done),
    .miso         (miso)
  );

  comm_spi_regbank regs_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_word      (wr_word),
    .rd_sel       (rd_sel),
    .data_rd_done (data_rd_done),
    .rd_word      (rd_word),
    .drdy_n       (drdy_n)
  );
endmodule

// File: tb/comm_spi_slave_tb.sv
module comm_spi_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EDGE_LAT   = 3;
  localparam int GAP        = 3;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n, sclk, cs_n, mosi, sample_valid;
  logic [15:0] sample_data;
  logic        miso, drdy_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  comm_spi_slave dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi),
    .miso         (miso),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .drdy_n       (drdy_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit cmp_on = 1'b0;

  // behavioural reference model
  logic        exp_miso = 1'b0;
  logic        exp_drdy_n = 1'b1;
  logic [23:0] m_val [8];
  int          m_st = 0;   // 0 command, 1 write, 2 read
  int          m_cnt = 0;
  int          m_len = 8;
  int          m_sel = 0;
  logic [31:0] m_acc = '0;
  logic        rd_q [$];

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int s);
    if (s == 3) return 16;
    if (s == 6 || s == 7) return 24;
    return 8;
  endfunction

  function automatic logic [23:0] peek(input int s);
    if (s == 0) return {16'h0, ~exp_drdy_n, 7'h0};
    return m_val[s];
  endfunction

  task automatic model_rise(input logic d);
    logic [7:0]  b;
    logic [23:0] v;
    logic [31:0] mask;
    case (m_st)
      0: begin
        m_acc = {m_acc[30:0], d};
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0;
          b = m_acc[7:0];
          if (!b[7]) begin
            m_sel = int'(b[6:4]);
            m_len = len_of(m_sel);
            if (b[3]) begin
              m_st = 2;
              v = peek(m_sel);
              for (int i = m_len - 1; i >= 0; i--) rd_q.push_back(v[i]);
            end else if (m_sel != 0) begin
              m_st = 1;
            end
          end
        end
      end
      1: begin
        m_acc = {m_acc[30:0], d};
        m_cnt++;
        if (m_cnt == m_len) begin
          mask = (32'd1 << m_len) - 32'd1;
          if (m_sel != 3) m_val[m_sel] = 24'(m_acc & mask);
          m_st = 0;
          m_cnt = 0;
        end
      end
      default: begin
        m_cnt++;
        if (m_cnt == m_len) begin
          m_st = 0;
          m_cnt = 0;
          exp_miso = 1'b0;
          if (m_sel == 3) exp_drdy_n = 1'b1;
        end
      end
    endcase
  endtask

  task automatic sclk_fall(input logic d);
    @(negedge clk);
    sclk = 1'b0;
    mosi = d;
    repeat (EDGE_LAT) @(posedge clk);
    if (m_st == 2 && rd_q.size() > 0) exp_miso = rd_q.pop_front();
    repeat (GAP) @(posedge clk);
  endtask

  task automatic sclk_rise(input logic d, output logic cap);
    @(negedge clk);
    cap = miso;
    sclk = 1'b1;
    repeat (EDGE_LAT) @(posedge clk);
    model_rise(d);
    repeat (GAP) @(posedge clk);
  endtask

  task automatic xfer(input int n, input logic [23:0] dout, output logic [23:0] din);
    logic c;
    din = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk_fall(dout[i]);
      sclk_rise(dout[i], c);
      din[i] = c;
    end
  endtask

  task automatic read_reg(input logic [7:0] cmd, input int n, output logic [23:0] v);
    logic [23:0] junk;
    xfer(8, {16'h0, cmd}, junk);
    xfer(n, 24'hFFFFFF, v);
  endtask

  task automatic write_reg(input logic [7:0] cmd, input int n, input logic [23:0] v);
    logic [23:0] junk;
    xfer(8, {16'h0, cmd}, junk);
    xfer(n, v, junk);
  endtask

  task automatic cs_set(input logic v);
    @(negedge clk);
    cs_n = v;
    repeat (EDGE_LAT) @(posedge clk);
    if (v) begin
      m_st = 0;
      m_cnt = 0;
      m_acc = '0;
      exp_miso = 1'b0;
      rd_q.delete();
    end
    repeat (GAP) @(posedge clk);
  endtask

  task automatic pulse(input logic [15:0] d);
    @(negedge clk);
    sample_valid = 1'b1;
    sample_data = d;
    @(posedge clk);
    m_val[3] = {8'h0, d};
    exp_drdy_n = 1'b0;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  // per-clock comparison against the model (R5, R8, R11)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R5 R11 miso per clock", {23'h0, miso}, {23'h0, exp_miso});
      check("R8 R11 drdy_n per clock", {23'h0, drdy_n}, {23'h0, exp_drdy_n});
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [23:0] junk;
    for (int i = 0; i < 8; i++) m_val[i] = '0;
    m_val[1] = 24'h01;
    m_val[7] = 24'h800000;
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; mosi = 1'b0;
    sample_valid = 1'b0; sample_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_on = 1'b1;

    check("R1 reset miso", {23'h0, miso}, 24'h0);
    check("R1 reset drdy_n", {23'h0, drdy_n}, 24'h1);
    cs_set(1'b0);

    read_reg(8'h18, 8, v);  check("R1 setup default", v, 24'h01);
    read_reg(8'h78, 24, v); check("R1 R3 full-scale default", v, 24'h800000);

    // R4: command and data as one 16-bit burst, MSB first
    write_reg(8'h10, 8, 24'hA5);
    read_reg(8'h18, 8, v);  check("R4 setup back-to-back write", v, 24'hA5);

    read_reg(8'h08, 8, v);  check("R8 status before sample", v, 24'h00);
    pulse(16'hBEEF);
    @(negedge clk);
    check("R8 drdy_n after strobe", {23'h0, drdy_n}, 24'h0);
    read_reg(8'h08, 8, v);  check("R8 status ready bit", v, 24'h80);
    check("R8 status read keeps flag", {23'h0, drdy_n}, 24'h0);

    read_reg(8'h38, 16, v); check("R3 data read", v, 24'hBEEF);
    check("R8 flag cleared by data read", {23'h0, drdy_n}, 24'h1);
    read_reg(8'h18, 8, v);  check("R5 mosi ignored during read", v, 24'hA5);

    // R6: 24-bit write in three pieces with idle gaps
    xfer(8, 24'h60, junk);
    xfer(8, 24'h12, junk); repeat (40) @(negedge clk);
    xfer(8, 24'h34, junk); repeat (40) @(negedge clk);
    xfer(8, 24'h56, junk);
    read_reg(8'h68, 24, v); check("R6 zero-scale pieces", v, 24'h123456);

    // R2: byte with bit 7 set is dropped, reserved bits ignored
    xfer(8, 24'h90, junk);
    read_reg(8'h18, 8, v);  check("R2 invalid command dropped", v, 24'hA5);
    read_reg(8'h1F, 8, v);  check("R2 reserved bits ignored", v, 24'hA5);

    write_reg(8'h30, 16, 24'h1111);
    read_reg(8'h38, 16, v); check("R3 data register read only", v, 24'hBEEF);

    // R7: abort in data phase and in command phase
    xfer(8, 24'h20, junk);
    xfer(4, 24'hF, junk);
    cs_set(1'b1); cs_set(1'b0);
    read_reg(8'h28, 8, v);  check("R7 aborted write not stored", v, 24'h00);
    xfer(5, 24'h1F, junk);
    cs_set(1'b1); cs_set(1'b0);
    read_reg(8'h18, 8, v);  check("R7 abort in command phase", v, 24'hA5);

    // R10: write to select 0 has no data phase
    xfer(8, 24'h00, junk);
    read_reg(8'h18, 8, v);  check("R10 select 0 write", v, 24'hA5);

    write_reg(8'h40, 8, 24'h3C);
    write_reg(8'h50, 8, 24'hC3);
    read_reg(8'h48, 8, v);  check("R3 test register", v, 24'h3C);
    read_reg(8'h58, 8, v);  check("R3 aux register", v, 24'hC3);

    // R9: sample during a data read does not disturb it
    pulse(16'h1234);
    fork
      read_reg(8'h38, 16, v);
      begin
        repeat (180) @(negedge clk);
        pulse(16'hCAFE);
      end
    join
    check("R9 snapshot at command", v, 24'h1234);
    check("R8 cleared at end of data read", {23'h0, drdy_n}, 24'h1);
    read_reg(8'h38, 16, v); check("R9 later read sees new sample", v, 24'hCAFE);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule